// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked system read and write an external asynchronous static RAM of 256K words by 16 bits. The host side presents a request with a read/write flag, an 18-bit word address, 16-bit write data and a 2-bit byte mask. The controller raises `req_ready` whenever it can take a request. It answers each accepted request with a one-cycle `done` pulse. For a read, the captured word is on `rd_data` in the same cycle as that pulse.

On the memory side the controller drives the address, one active-low and one active-high chip enable, the write and output enables, per-lane byte selects, and a shared tri-state data bus. Every memory timing figure is an elaboration-time parameter in nanoseconds. Each is turned into whole clock cycles by rounding up against the clock period, and no phase is shorter than one cycle. The write pulse is also stretched so that the controller's data is on the bus for the full data-setup time before the strobe ends.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `req_ready` is 1, `done` is 0, `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1 and both byte selects are 1.
- R2: Whenever the controller is ready for a request, the memory is deselected: `mem_ce_n`=1 and `mem_ce`=0.
- R3: Mask bit 0 selects the low lane (data bits 7:0, `mem_lb_n`), and mask bit 1 selects the high lane (bits 15:8, `mem_ub_n`). A write with mask 2'b11 stores all 16 bits, and a later read with mask 2'b11 returns them.
- R4: A write with exactly one mask bit set changes only that lane of the addressed word.
- R5: A read with exactly one mask bit set returns that lane's memory bits, and the other lane of `rd_data` reads as zero.
- R6: Whenever `mem_we_n` is 0, `mem_oe_n` is 1 and both chip enables are active.
- R7: `mem_addr` does not change while `mem_we_n` is 0.
- R8: `mem_we_n` stays low for exactly WP = max(ceil(T_WP/T_clk), ceil(T_DW/T_clk)+1) cycles. The controller drives `mem_dq` only from the second low cycle through the last one.
- R9: A read keeps `mem_oe_n` low for max(ceil(T_AA/T_clk), ceil(T_OE/T_clk)) cycles and captures the bus on the last of them. `done` comes 1+RD cycles after acceptance (6 with the defaults). A write's `done` comes 1+AS+WP cycles after acceptance (6 with the defaults).
- R10: After a write, `req_ready` returns AS+WP+WR+1 cycles after acceptance (7 with the defaults). After a read, it returns RD+OHZ+1 cycles after acceptance (8 with the defaults). `req_ready` is low after every rise of `mem_oe_n`.
- R11: A request with mask 2'b00 gives `done` in the next cycle and never selects or strobes the memory. Stored data is unchanged and `req_ready` stays 1.
- R12: Addresses 0 and 2^18-1 are written and read back without aliasing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with `done` after a read |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_lb_n | output | 1 | Active-low low-lane select |
| mem_ub_n | output | 1 | Active-low high-lane select |
| mem_dq | inout | 16 | Shared data bus |

## Verification
Some rules are checked by the assertions on every cycle. These are the bus-protocol rules: output enable held off and the chip selected during the write strobe, a stable address under the strobe, bus drive confined to the strobe after its first cycle, and the exact strobe length. They also cover the deselected memory while ready, the busy state after output turn-off, the silence after a zero-mask request, and the zeroed unselected read lane. Other behaviour only the directed scenarios can show, because it needs a memory model and a host-side expectation. That covers the data path through the memory, lane isolation on partial writes, the completion and ready latencies measured from acceptance, and the separation of the lowest and highest addresses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WRECOV,
    ST_RACCESS,
    ST_RTURN
  } phase_e;

  // whole cycles covering t_ns, never less than one
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                            input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          expired
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          sel,
  input  logic [LW-1:0] din,
  output logic [LW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (capture)
      rdata <= sel ? din : '0;
  end

  // R5
  unsel_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture && !sel |=> rdata == '0);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int LANES    = 2,
  parameter int CLK_NS   = 10,
  parameter int T_AS_NS  = 0,
  parameter int T_WP_NS  = 40,
  parameter int T_DW_NS  = 25,
  parameter int T_WR_NS  = 0,
  parameter int T_AA_NS  = 50,
  parameter int T_OE_NS  = 30,
  parameter int T_OHZ_NS = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_bmask,
  output logic             req_ready,
  output logic             done,
  output logic [DW-1:0]    rd_data,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_ce,
  output logic             mem_we_n,
  output logic             mem_oe_n,
  output logic             mem_lb_n,
  output logic             mem_ub_n,
  inout  wire  [DW-1:0]    mem_dq
);

  localparam int LW      = DW / LANES;
  localparam int AS_CYC  = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int WP_CYC  = max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS) + 1);
  localparam int WR_CYC  = ns_to_cyc(T_WR_NS, CLK_NS);
  localparam int RD_CYC  = max2(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int OHZ_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int MAX_CYC = max2(max2(AS_CYC, WP_CYC), max2(max2(WR_CYC, RD_CYC), OHZ_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1);

  phase_e            state_q, state_d;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic [LANES-1:0]  mask_q;
  logic              done_q;
  logic              accept, zero_req, load, expired;
  logic [CW-1:0]     load_val, cnt;
  // named internal events used by the assertions
  logic              drv_en, capture, wr_end, sel_st;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign zero_req  = accept && (req_bmask == '0);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      ST_IDLE: if (accept && !zero_req) begin
        load = 1'b1;
        if (req_write) begin
          state_d  = ST_WSETUP;
          load_val = CW'(AS_CYC - 1);
        end else begin
          state_d  = ST_RACCESS;
          load_val = CW'(RD_CYC - 1);
        end
      end
      ST_WSETUP: if (expired) begin
        state_d = ST_WPULSE; load = 1'b1; load_val = CW'(WP_CYC - 1);
      end
      ST_WPULSE: if (expired) begin
        state_d = ST_WRECOV; load = 1'b1; load_val = CW'(WR_CYC - 1);
      end
      ST_WRECOV: if (expired) state_d = ST_IDLE;
      ST_RACCESS: if (expired) begin
        state_d = ST_RTURN; load = 1'b1; load_val = CW'(OHZ_CYC - 1);
      end
      ST_RTURN: if (expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign capture = (state_q == ST_RACCESS) && expired;
  assign wr_end  = (state_q == ST_WPULSE) && expired;
  assign drv_en  = (state_q == ST_WPULSE) && (cnt != CW'(WP_CYC - 1));
  assign sel_st  = (state_q == ST_WSETUP) || (state_q == ST_WPULSE) ||
                   (state_q == ST_WRECOV) || (state_q == ST_RACCESS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= zero_req || capture || wr_end;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_bmask;
      end
    end
  end

  sram_phase_timer #(.CW(CW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .cnt      (cnt),
    .expired  (expired)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_capture #(.LW(LW)) i_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .sel     (mask_q[g]),
      .din     (mem_dq[g*LW +: LW]),
      .rdata   (rd_data[g*LW +: LW])
    );
  end

  assign mem_dq   = drv_en ? wdata_q : {DW{1'bz}};
  assign done     = done_q;
  assign mem_addr = addr_q;
  assign mem_ce_n = !sel_st;
  assign mem_ce   = sel_st;
  assign mem_we_n = (state_q != ST_WPULSE);
  assign mem_oe_n = (state_q != ST_RACCESS);
  assign mem_lb_n = !(sel_st && mask_q[0]);
  assign mem_ub_n = !(sel_st && mask_q[LANES-1]);

  // strobe length tracker for the assertions
  logic [CW:0] we_low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)        we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
    else               we_low_cnt <= '0;
  end

  // R2
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n && !mem_ce);

  // R6
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n && !mem_ce_n && mem_ce);

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n && $past(!mem_we_n) |-> $stable(mem_addr));

  // R8
  drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> !mem_we_n && $past(!mem_we_n));

  // R8
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> we_low_cnt == (CW+1)'(WP_CYC));

  // R10
  turnoff_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !req_ready);

  // R11
  zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> mem_ce_n && mem_we_n && mem_oe_n && done);

endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int CLK_NS = 10;
  // expected cycle counts, derived from the requirement formulas
  localparam int E_AS  = 1;                              // 0 ns -> minimum one cycle
  localparam int E_WP  = ((25 + CLK_NS - 1) / CLK_NS) + 1 > (40 + CLK_NS - 1) / CLK_NS ?
                         ((25 + CLK_NS - 1) / CLK_NS) + 1 : (40 + CLK_NS - 1) / CLK_NS;
  localparam int E_WR  = 1;
  localparam int E_RD  = (50 + CLK_NS - 1) / CLK_NS;     // larger than the 30 ns term
  localparam int E_OHZ = (20 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_bmask = '0;
  logic        req_ready, done;
  logic [15:0] rd_data;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
  wire  [15:0] mem_dq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .req_bmask,
    .req_ready, .done, .rd_data, .mem_addr, .mem_ce_n, .mem_ce, .mem_we_n,
    .mem_oe_n, .mem_lb_n, .mem_ub_n, .mem_dq
  );

  // ---------------- memory model ----------------
  logic [15:0] model_mem [logic [17:0]];
  logic [15:0] model_rd, wr_sample;
  logic [17:0] wr_addr;
  logic        wr_lb, wr_ub;
  logic        model_oe;

  always @* model_rd = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 16'h0000;
  assign model_oe = !mem_ce_n && mem_ce && !mem_oe_n && mem_we_n && !(mem_lb_n && mem_ub_n);
  assign mem_dq   = model_oe ? model_rd : 16'hzzzz;

  always @(negedge clk) if (!mem_we_n) begin
    wr_sample = mem_dq; wr_addr = mem_addr; wr_lb = !mem_lb_n; wr_ub = !mem_ub_n;
  end

  always @(posedge mem_we_n) if (rst_n) begin
    logic [15:0] w;
    w = model_mem.exists(wr_addr) ? model_mem[wr_addr] : 16'h0000;
    if (wr_lb) w[7:0]  = wr_sample[7:0];
    if (wr_ub) w[15:8] = wr_sample[15:8];
    model_mem[wr_addr] = w;
  end

  // ---------------- checking ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle monitor
  int          we_len = 0;
  logic [17:0] we_addr;
  always @(negedge clk) if (rst_n && !finished) begin
    if (req_ready) check("R2 deselected while ready", {mem_ce_n, mem_ce}, 2'b10);
    if (!mem_we_n) begin
      check("R6 oe/ce during strobe", {mem_oe_n, mem_ce_n, mem_ce}, 3'b101);
      if (we_len == 0) we_addr = mem_addr;
      else check("R7 address held", mem_addr, we_addr);
      we_len++;
    end else if (we_len != 0) begin
      check("R8 strobe length", we_len, E_WP);
      we_len = 0;
    end
  end

  // one access; latencies counted in falling edges after the accepting edge
  task automatic access(input logic wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rdv,
                        output int dlat, output int rlat);
    int n;
    dlat = 0; rlat = 0; rdv = '0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (n = 1; n < 50; n++) begin
      if (done && dlat == 0) begin dlat = n; rdv = rd_data; end
      if (req_ready) begin rlat = n; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 ready", req_ready, 1'b1);
    check("R1 done", done, 1'b0);
    check("R1 strobes", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 6'b101111);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {req_ready, done, mem_ce_n, mem_ce, mem_we_n, mem_oe_n}, 6'b101011);
  endtask

  task automatic t_word;
    logic [15:0] r; int dl, rl;
    access(1'b1, 18'h00123, 16'hBEEF, 2'b11, r, dl, rl);
    check("R9 write done latency", dl, 1 + E_AS + E_WP);
    check("R10 write ready latency", rl, E_AS + E_WP + E_WR + 1);
    access(1'b0, 18'h00123, 16'h0000, 2'b11, r, dl, rl);
    check("R3 word readback", r, 16'hBEEF);
    check("R9 read done latency", dl, 1 + E_RD);
    check("R10 read ready latency", rl, E_RD + E_OHZ + 1);
  endtask

  task automatic t_byte_write;
    logic [15:0] r; int dl, rl;
    access(1'b1, 18'h00123, 16'h5A77, 2'b10, r, dl, rl);
    access(1'b0, 18'h00123, 16'h0000, 2'b11, r, dl, rl);
    check("R4 high-lane write", r, 16'h5AEF);
    access(1'b1, 18'h00123, 16'h3CC3, 2'b01, r, dl, rl);
    access(1'b0, 18'h00123, 16'h0000, 2'b11, r, dl, rl);
    check("R4 low-lane write", r, 16'h5AC3);
  endtask

  task automatic t_byte_read;
    logic [15:0] r; int dl, rl;
    access(1'b0, 18'h00123, 16'h0000, 2'b01, r, dl, rl);
    check("R5 low-lane read", r, 16'h00C3);
    access(1'b0, 18'h00123, 16'h0000, 2'b10, r, dl, rl);
    check("R5 high-lane read", r, 16'h5A00);
  endtask

  task automatic t_zero_mask;
    logic [15:0] r; int dl, rl; int strobes;
    strobes = 0;
    fork
      access(1'b1, 18'h00123, 16'hFFFF, 2'b00, r, dl, rl);
      repeat (4) begin @(negedge clk); if (!mem_ce_n || mem_ce || !mem_we_n) strobes++; end
    join
    check("R11 done latency", dl, 1);
    check("R11 ready stays", rl, 1);
    check("R11 no strobe", strobes, 0);
    access(1'b0, 18'h00123, 16'h0000, 2'b11, r, dl, rl);
    check("R11 data unchanged", r, 16'h5AC3);
  endtask

  task automatic t_extremes;
    logic [15:0] r; int dl, rl;
    access(1'b1, 18'h00000, 16'h1111, 2'b11, r, dl, rl);
    access(1'b1, 18'h3FFFF, 16'hE00E, 2'b11, r, dl, rl);
    access(1'b0, 18'h00000, 16'h0000, 2'b11, r, dl, rl);
    check("R12 lowest address", r, 16'h1111);
    access(1'b0, 18'h3FFFF, 16'h0000, 2'b11, r, dl, rl);
    check("R12 highest address", r, 16'hE00E);
  endtask

  task automatic t_back_to_back;
    logic [15:0] r; int dl, rl;
    for (int i = 0; i < 4; i++)
      access(1'b1, 18'h01000 + 18'(i), 16'hA500 + 16'(i * 7), 2'b11, r, dl, rl);
    for (int i = 0; i < 4; i++) begin
      access(1'b0, 18'h01000 + 18'(i), 16'h0000, 2'b11, r, dl, rl);
      check("R3 back-to-back readback", r, 16'hA500 + 16'(i * 7));
    end
  endtask

  task automatic summary;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_word();
    t_byte_write();
    t_byte_read();
    t_zero_mask();
    t_extremes();
    t_back_to_back();
    repeat (3) @(negedge clk);
    summary();
  end

endmodule